// File: doc/BRIEF.md
# Teletext Request and Insertion Window Timer

This block decides, line by line, when a serial teletext source must be asked for data and when that data is accepted into the video line. It counts pixel clocks from each line sync and counts lines from each field sync. Each field parity has its own programmable band of lines that may carry teletext. On a line inside the active band, a request output rises at a programmed pixel position. After a programmed delay, which never goes below two clocks, the block opens an internal insertion window. While the window is open, the serial input is passed through as valid data.

The window lasts a fixed number of bits, and a format bit chooses that number. One setting gives the 360-bit European format and the other gives the 288-bit 60 Hz format. The request stays high from its rising edge to the end of the window. The timing generator supplies the line and field references, and a register block supplies the configuration inputs.

Top module: `ttx_window_timer`

## Requirements
- R1: After reset, `ttx_req`, `ins_win` and `ins_data` are low.
- R2: The pixel count is 0 in the cycle after `line_sync` is sampled high and rises by one each cycle. On a line that may carry teletext, `ttx_req` is first high at pixel count `cfg_hstart + 1`. It rises at most once per line.
- R3: A line sampled with `line_sync` and `field_sync` both high is line 1 of a field. Its `field_odd` value (1 = odd) sets the field parity. In an odd field, lines `cfg_odd_first` to `cfg_odd_last` inclusive may carry teletext. In an even field, lines `cfg_even_first` to `cfg_even_last` inclusive may carry teletext. When first is greater than last, no line of that parity carries teletext.
- R4: `ins_win` first goes high D cycles after `ttx_req` first goes high, where D = `cfg_delay` when that value is 2 or more, and D = 2 otherwise.
- R5: `ins_win` stays high for 360 consecutive cycles when `fmt_us` = 0, and for 288 cycles when `fmt_us` = 1.
- R6: `ttx_req` stays high without a gap from its rise until the end of the window, and falls in the same cycle as `ins_win`. It is high for D + window-length cycles per line.
- R7: While `ttx_en` is low, `ttx_req` is never raised. If `ttx_en` is dropped during a request, `ttx_req` and `ins_win` are low from the next cycle onward.
- R8: `ins_data` equals `ttx_in` while `ins_win` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sync | input | 1 | One-cycle pulse at the start of each line |
| field_sync | input | 1 | High together with `line_sync` on the first line of a field |
| field_odd | input | 1 | Field parity, sampled on a field start (1 = odd) |
| ttx_en | input | 1 | Teletext insertion enable |
| fmt_us | input | 1 | 0 = 360-bit European window, 1 = 288-bit 60 Hz window |
| cfg_hstart | input | PIX_W | Pixel position that triggers the request |
| cfg_delay | input | DLY_W | Request-to-data delay in clocks (minimum 2) |
| cfg_odd_first | input | LINE_W | First teletext line, odd field |
| cfg_odd_last | input | LINE_W | Last teletext line, odd field |
| cfg_even_first | input | LINE_W | First teletext line, even field |
| cfg_even_last | input | LINE_W | Last teletext line, even field |
| ttx_in | input | 1 | Serial teletext bit stream |
| ttx_req | output | 1 | Request to the teletext source |
| ins_win | output | 1 | Internal insertion window |
| ins_data | output | 1 | Teletext input gated by the window |

## Verification
The assertions check, on every cycle, the relations between the request and the window. The window never opens without an active request. The request has been high for at least two cycles when the window opens. Both signals fall together. A disabled block raises no request. No window runs past the longest bit count. The bench scenarios are the only place that shows the exact pixel position of the request, the line selection per field parity (empty bands included), and the clamping of small delays. They also show the exact window lengths of both formats and the gating of the serial data. These values depend on counts across whole lines and fields.

// File: rtl/ttx_window_timer.sv
module ttx_window_timer #(
  parameter int PIX_W   = 11,
  parameter int LINE_W  = 10,
  parameter int DLY_W   = 8,
  parameter int BITS_EU = 360,
  parameter int BITS_US = 288,
  parameter int MIN_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic              field_sync,
  input  logic              field_odd,
  input  logic              ttx_en,
  input  logic              fmt_us,
  input  logic [PIX_W-1:0]  cfg_hstart,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [LINE_W-1:0] cfg_odd_first,
  input  logic [LINE_W-1:0] cfg_odd_last,
  input  logic [LINE_W-1:0] cfg_even_first,
  input  logic [LINE_W-1:0] cfg_even_last,
  input  logic              ttx_in,
  output logic              ttx_req,
  output logic              ins_win,
  output logic              ins_data
);

  localparam int CNT_W = $clog2(BITS_EU + (1 << DLY_W));
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_t;

  st_t              st;
  logic [PIX_W-1:0] pix;
  logic [LINE_W-1:0] line;
  logic             odd_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               pix <= '0;
    else if (line_sync)       pix <= '0;
    else if (pix != PIX_MAX)  pix <= pix + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line  <= '0;
      odd_q <= 1'b0;
    end else if (line_sync) begin
      if (field_sync) begin
        line  <= LINE_W'(1);
        odd_q <= field_odd;
      end else if (line != LINE_MAX) begin
        line <= line + 1'b1;
      end
    end
  end

  wire in_odd  = odd_q  && line >= cfg_odd_first  && line <= cfg_odd_last;
  wire in_even = !odd_q && line >= cfg_even_first && line <= cfg_even_last;
  wire trig    = ttx_en && (in_odd || in_even) && pix == cfg_hstart;

  wire [CNT_W-1:0] d_eff  = (cfg_delay < DLY_W'(MIN_DLY)) ? CNT_W'(MIN_DLY) : CNT_W'(cfg_delay);
  wire [CNT_W-1:0] n_bits = fmt_us ? CNT_W'(BITS_US) : CNT_W'(BITS_EU);

  always_ff @(posedge clk) begin
    if (!rst_n || !ttx_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (trig) begin
          st  <= S_WAIT;
          cnt <= d_eff;
        end
        S_WAIT: if (cnt == CNT_W'(1)) begin
          st  <= S_SEND;
          cnt <= n_bits;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_SEND: if (cnt == CNT_W'(1)) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ttx_req  = st != S_IDLE;
  assign ins_win  = st == S_SEND;
  assign ins_data = ins_win & ttx_in;

  logic [CNT_W-1:0] win_run;
  always_ff @(posedge clk) begin
    if (!rst_n || !ins_win) win_run <= '0;
    else                    win_run <= win_run + 1'b1;
  end

  // R7
  disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ttx_en |=> !ttx_req);

  // R6
  win_inside_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_win |-> ttx_req);

  // R6
  fall_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ins_win) |-> $fell(ttx_req));

  // R4
  min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_win) |-> ($past(ttx_req) && $past(ttx_req, 2)));

  // R2
  req_before_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ttx_req) |-> !ins_win);

  // R5
  win_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_win |-> win_run < CNT_W'(BITS_EU));

endmodule

// File: tb/ttx_window_timer_tb.sv
module ttx_window_timer_tb;
  localparam int LINE_LEN = 700;

  logic clk = 0, rst_n = 0;
  logic line_sync = 0, field_sync = 0, field_odd = 0, ttx_en = 0, fmt_us = 0, ttx_in = 0;
  logic [10:0] cfg_hstart = 0;
  logic [7:0]  cfg_delay = 0;
  logic [9:0]  cfg_odd_first = 0, cfg_odd_last = 0, cfg_even_first = 0, cfg_even_last = 0;
  logic ttx_req, ins_win, ins_data;

  always #4 clk = ~clk;

  ttx_window_timer u_dut (.*);

  typedef struct { int rise; int wst; int wlen; int rlen; int dcnt; string tag; } rec_t;
  rec_t exq[$];
  int errors = 0, checks = 0;
  bit mon_on = 0, started = 0;
  int p = 0;
  rec_t ob;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (line_sync) begin
        if (started) begin
          if (exq.size() == 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: line without expected item");
          end else begin
            rec_t e;
            e = exq.pop_front();
            checks++;
            if (ob.rise != e.rise || ob.wst != e.wst || ob.wlen != e.wlen ||
                ob.rlen != e.rlen || ob.dcnt != e.dcnt) begin
              errors++;
              $display("FAIL %s: rise/wst/wlen/rlen/data actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                e.tag, ob.rise, ob.wst, ob.wlen, ob.rlen, ob.dcnt,
                e.rise, e.wst, e.wlen, e.rlen, e.dcnt);
            end
          end
        end
        started = 1;
        p = 0;
        ob = '{-1, -1, 0, 0, 0, ""};
      end else p++;
      if (ttx_req) begin if (ob.rise < 0) ob.rise = p; ob.rlen++; end
      if (ins_win) begin if (ob.wst < 0) ob.wst = p; ob.wlen++; end
      if (ins_data) ob.dcnt++;
    end
  end

  task automatic drive_line(input bit vs, input bit odd);
    @(negedge clk);
    line_sync = 1; field_sync = vs; field_odd = odd;
    @(negedge clk);
    line_sync = 0; field_sync = 0;
    repeat (LINE_LEN - 2) @(negedge clk);
  endtask

  task automatic run_field(input bit odd, input int nl, input string tag);
    for (int l = 1; l <= nl; l++) begin
      int f, la, d, n;
      rec_t e;
      f  = odd ? int'(cfg_odd_first) : int'(cfg_even_first);
      la = odd ? int'(cfg_odd_last)  : int'(cfg_even_last);
      d  = (cfg_delay < 2) ? 2 : int'(cfg_delay);
      n  = fmt_us ? 288 : 360;
      if (ttx_en && l >= f && l <= la)
        e = '{int'(cfg_hstart) + 1, int'(cfg_hstart) + 1 + d, n, d + n, ttx_in ? n : 0, tag};
      else
        e = '{-1, -1, 0, 0, 0, tag};
      exq.push_back(e);
      drive_line(l == 1, odd);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (ttx_req || ins_win || ins_data) begin
      errors++;
      $display("FAIL R1: req/win/data actual %b%b%b expected 000", ttx_req, ins_win, ins_data);
    end

    mon_on = 1;
    // European window, odd and even bands differ (R3, R5, R8)
    ttx_en = 1; fmt_us = 0; ttx_in = 1; cfg_hstart = 11'h42; cfg_delay = 2;
    cfg_odd_first = 5; cfg_odd_last = 8; cfg_even_first = 4; cfg_even_last = 6;
    run_field(1, 10, "R3 R5 R6 R8 odd");
    run_field(0, 9, "R3 R5 R6 R8 even");
    // 60 Hz window, longer delay, data low (R2, R4, R5, R8)
    fmt_us = 1; ttx_in = 0; cfg_hstart = 11'h54; cfg_delay = 9;
    cfg_odd_first = 6; cfg_odd_last = 7;
    run_field(1, 8, "R2 R4 R5 R8 us");
    // delay clamp (R4)
    fmt_us = 0; ttx_in = 1; cfg_delay = 0; cfg_odd_first = 2; cfg_odd_last = 2;
    run_field(1, 3, "R4 clamp0");
    cfg_delay = 1;
    run_field(1, 3, "R4 clamp1");
    // disabled (R7)
    ttx_en = 0; cfg_odd_first = 1; cfg_odd_last = 4;
    run_field(1, 4, "R7 disabled");
    // empty band first > last (R3)
    ttx_en = 1; cfg_odd_first = 5; cfg_odd_last = 3;
    run_field(1, 6, "R3 empty band");
    @(negedge clk);
    line_sync = 1;
    @(negedge clk);
    line_sync = 0;
    @(negedge clk);
    mon_on = 0;
    checks++;
    if (exq.size() != 0) begin
      errors++;
      $display("FAIL R3: leftover expected lines actual %0d expected 0", exq.size());
    end

    // abort by dropping enable (R7)
    cfg_odd_first = 1; cfg_odd_last = 1; cfg_delay = 3;
    @(negedge clk);
    line_sync = 1; field_sync = 1; field_odd = 1;
    @(negedge clk);
    line_sync = 0; field_sync = 0;
    for (int i = 0; i < LINE_LEN && !ins_win; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    checks++;
    if (!ins_win) begin
      errors++;
      $display("FAIL R7: window before abort actual 0 expected 1");
    end
    ttx_en = 0;
    @(negedge clk);
    checks++;
    if (ttx_req || ins_win) begin
      errors++;
      $display("FAIL R7: after enable drop req/win actual %b%b expected 00", ttx_req, ins_win);
    end
    summary();
  end
endmodule